// File: doc/BRIEF.md
# Local Interrupt Level Router

This block is the interrupt front end of one processor on a multiprocessor board. Four local request lines feed it: a slot-directed inter-processor request, a broadcast inter-processor request, a diagnostic serial port and a local timer. A packed routing word gives each source a 3-bit priority level. Level 0 turns a source off. A nonzero level N sets pending bit N, and bit N of the mask register blocks that level. The block holds the pending bits and presents them both raw and with the mask applied. It also holds two in-service flags, which an acknowledge sets.

A command port takes 8-bit command codes. One code sends an inter-processor interrupt to a numbered slot. One sends a broadcast interrupt. One forwards a request at a given level. Two clear the in-service flags. A busy flag in bit 8 of the command status covers the whole run of a command. Any write that arrives while the flag is set is dropped. Vector generation and timer counting live elsewhere.

Top module: `lir_router`

## Requirements
- R1: After reset the routing word reads 0x1032 (slot request at level 1, timer at level 2, serial port at level 3, broadcast request off). Mask, pending, in-service, command status and `ipi_valid_o` all read 0.
- R2: A routing write stores the timer level in bits 2:0, the serial port level in bits 6:4, the broadcast request level in bits 10:8 and the slot request level in bits 14:12. Bits 3, 7, 11 and 15 always read 0.
- R3: A source that is high at a clock edge while its field holds N≠0 sets pending bit N at that edge. A source whose field is 0 changes nothing.
- R4: Pending bit 0 is never set. Sources that share a level share one pending bit.
- R5: `masked_pending_o` equals the pending bits ANDed with the inverted mask. Masking a level does not stop its pending bit from being captured.
- R6: An acknowledge with level L and selector S sets in-service bit S. It clears pending bit L unless a source routed to L is high in the same cycle, in which case the bit stays set.
- R7: A command write while not busy is accepted at that edge. From then on the status reads {1'b1, code}.
- R8: Code 0x60+s (s in 0..15) drives `ipi_valid_o` high for exactly one cycle, starting at the edge after acceptance, with kind 0 (slot) and target s.
- R9: Code 0xE0 drives one `ipi_valid_o` cycle with kind 1 (broadcast) and target 0.
- R10: Code 0x20+L (L in 0..7) drives one `ipi_valid_o` cycle with kind 2 (forward at level) and target L.
- R11: Code 0xE8 clears in-service bit 0 and code 0xE9 clears in-service bit 1. The clear takes effect at the edge after acceptance, and neither code drives `ipi_valid_o`.
- R12: The busy bit stays set for BUSY_CYCLES+1 cycles after acceptance (4 by default). A command write while busy changes neither the status nor the in-service bits, and drives no `ipi_valid_o`.
- R13: Any other code is accepted and makes the block busy. It drives no `ipi_valid_o` and leaves the in-service bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_slot_i | input | 1 | Slot-directed inter-processor request |
| src_global_i | input | 1 | Broadcast inter-processor request |
| src_uart_i | input | 1 | Diagnostic serial port request |
| src_timer_i | input | 1 | Local timer request |
| route_we_i | input | 1 | Routing word write strobe |
| route_wdata_i | input | 16 | Routing word write data |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data, bit N blocks level N |
| ack_valid_i | input | 1 | Acknowledge a level into service |
| ack_level_i | input | 3 | Level being acknowledged |
| ack_sel_i | input | 1 | In-service bit to set |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 8 | Command code |
| route_o | output | 16 | Routing word readback |
| mask_o | output | 8 | Mask readback |
| pending_o | output | 8 | Pending bits per level |
| masked_pending_o | output | 8 | Pending bits with the mask applied |
| inserv_o | output | 2 | In-service bits |
| cmd_status_o | output | 9 | Bit 8 busy, bits 7:0 last accepted code |
| ipi_valid_o | output | 1 | One-cycle outgoing interrupt strobe |
| ipi_kind_o | output | 2 | 0 slot, 1 broadcast, 2 forward at level |
| ipi_target_o | output | 4 | Slot number or level |

## Verification
The assertions assume every input is driven to a known value from reset onward. They also assume `ack_level_i` and `ack_sel_i` matter only while `ack_valid_i` is high. Same-cycle collisions of an acknowledge with a clear command on the same in-service bit are left out of the checks. The stimulus never makes such a collision. It changes inputs only between edges and routes sources to chosen levels before it pulses them. It issues each command only after the busy bit has dropped, except for the one deliberate write into a busy window.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int LVL_W   = 3;
  localparam int NLVL    = 1 << LVL_W;
  localparam int SRC_N   = 4;
  localparam int FIELD_W = LVL_W + 1;
  localparam int ROUTE_W = SRC_N * FIELD_W;
  localparam int CMD_W   = 8;
  localparam int TGT_W   = 4;
  localparam int ISV_N   = 2;

  // source index equals its field position in the routing word
  localparam int SRC_TIMER  = 0;
  localparam int SRC_UART   = 1;
  localparam int SRC_GLOBAL = 2;
  localparam int SRC_SLOT   = 3;

  typedef enum logic [1:0] {
    IPI_SLOT    = 2'd0,
    IPI_GLOBAL  = 2'd1,
    IPI_REBCAST = 2'd2
  } ipi_kind_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SLOT,
    OP_GLOBAL,
    OP_REBCAST,
    OP_CLR0,
    OP_CLR1
  } cmd_op_e;

  function automatic logic [ROUTE_W-1:0] route_valid_mask();
    logic [ROUTE_W-1:0] m;
    m = '0;
    for (int i = 0; i < SRC_N; i++) m[i*FIELD_W +: LVL_W] = '1;
    return m;
  endfunction

  function automatic logic [ROUTE_W-1:0] route_pack(logic [LVL_W-1:0] lt,
                                                     logic [LVL_W-1:0] lu,
                                                     logic [LVL_W-1:0] lg,
                                                     logic [LVL_W-1:0] ls);
    logic [ROUTE_W-1:0] r;
    r = '0;
    r[SRC_TIMER*FIELD_W  +: LVL_W] = lt;
    r[SRC_UART*FIELD_W   +: LVL_W] = lu;
    r[SRC_GLOBAL*FIELD_W +: LVL_W] = lg;
    r[SRC_SLOT*FIELD_W   +: LVL_W] = ls;
    return r;
  endfunction

  function automatic logic [LVL_W-1:0] route_level(logic [ROUTE_W-1:0] r, int idx);
    return r[idx*FIELD_W +: LVL_W];
  endfunction

  function automatic cmd_op_e cmd_decode(logic [CMD_W-1:0] c);
    cmd_op_e op;
    if (c == 8'hE0)              op = OP_GLOBAL;
    else if (c == 8'hE8)         op = OP_CLR0;
    else if (c == 8'hE9)         op = OP_CLR1;
    else if (c[7:4] == 4'h6)     op = OP_SLOT;
    else if (c[7:3] == 5'b00100) op = OP_REBCAST;
    else                         op = OP_NONE;
    return op;
  endfunction

  localparam logic [ROUTE_W-1:0] ROUTE_VALID   = route_valid_mask();
  localparam logic [ROUTE_W-1:0] ROUTE_DEFAULT = route_pack(3'd2, 3'd3, 3'd0, 3'd1);
endpackage

// File: rtl/lir_route.sv
module lir_route
  import lir_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [ROUTE_W-1:0] wdata_i,
  input  logic [SRC_N-1:0]   src_req_i,
  output logic [ROUTE_W-1:0] route_o,
  output logic [NLVL-1:0]    lvl_hit_o
);
  logic [ROUTE_W-1:0] route_q;
  logic [NLVL-1:0]    src_vec [SRC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    route_q <= ROUTE_DEFAULT;
    else if (we_i) route_q <= wdata_i & ROUTE_VALID;
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    logic [LVL_W-1:0] lvl;
    assign lvl        = route_level(route_q, g);
    assign src_vec[g] = (src_req_i[g] && (lvl != '0)) ? (NLVL'(1) << lvl) : '0;
  end

  always_comb begin
    lvl_hit_o = '0;
    for (int s = 0; s < SRC_N; s++) lvl_hit_o = lvl_hit_o | src_vec[s];
  end

  assign route_o = route_q;
endmodule

// File: rtl/lir_pending.sv
module lir_pending
  import lir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLVL-1:0]  lvl_hit_i,
  input  logic             ack_valid_i,
  input  logic [LVL_W-1:0] ack_level_i,
  input  logic             mask_we_i,
  input  logic [NLVL-1:0]  mask_wdata_i,
  output logic [NLVL-1:0]  pending_o,
  output logic [NLVL-1:0]  mask_o,
  output logic [NLVL-1:0]  masked_pending_o
);
  logic [NLVL-1:0] mask_q;
  logic [NLVL-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    if (g == 0) begin : g_none
      assign pend_q[g] = 1'b0;
    end else begin : g_bit
      logic clr;
      assign clr = ack_valid_i && (ack_level_i == LVL_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pend_q[g] <= 1'b0;
        else if (lvl_hit_i[g]) pend_q[g] <= 1'b1;
        else if (clr)          pend_q[g] <= 1'b0;
      end
    end
  end

  assign pending_o        = pend_q;
  assign mask_o           = mask_q;
  assign masked_pending_o = pend_q & ~mask_q;
endmodule

// File: rtl/lir_cmd.sv
module lir_cmd
  import lir_pkg::*;
#(
  parameter int BUSY_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             ack_valid_i,
  input  logic             ack_sel_i,
  output logic [CMD_W:0]   status_o,
  output logic [ISV_N-1:0] inserv_o,
  output logic             ipi_valid_o,
  output logic [1:0]       ipi_kind_o,
  output logic [TGT_W-1:0] ipi_target_o,
  output logic             accept_o,
  output logic             exec_o
);
  localparam int CNT_MAX = BUSY_CYCLES + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] cmd_q;
  logic             busy;
  cmd_op_e          op;
  logic [ISV_N-1:0] isv_q;

  assign busy     = (cnt_q != '0);
  assign accept_o = cmd_we_i && !busy;
  assign exec_o   = (cnt_q == CNT_W'(CNT_MAX));
  assign op       = cmd_decode(cmd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmd_q <= '0;
    end else if (accept_o) begin
      cnt_q <= CNT_W'(CNT_MAX);
      cmd_q <= cmd_wdata_i;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipi_valid_o  <= 1'b0;
      ipi_kind_o   <= IPI_SLOT;
      ipi_target_o <= '0;
    end else begin
      ipi_valid_o <= 1'b0;
      if (exec_o) begin
        case (op)
          OP_SLOT: begin
            ipi_valid_o  <= 1'b1;
            ipi_kind_o   <= IPI_SLOT;
            ipi_target_o <= cmd_q[TGT_W-1:0];
          end
          OP_GLOBAL: begin
            ipi_valid_o  <= 1'b1;
            ipi_kind_o   <= IPI_GLOBAL;
            ipi_target_o <= '0;
          end
          OP_REBCAST: begin
            ipi_valid_o  <= 1'b1;
            ipi_kind_o   <= IPI_REBCAST;
            ipi_target_o <= TGT_W'(cmd_q[LVL_W-1:0]);
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar b = 0; b < ISV_N; b++) begin : g_isv
    logic set_b;
    logic clr_b;
    assign set_b = ack_valid_i && (ack_sel_i == b[0]);
    assign clr_b = exec_o && (op == ((b == 0) ? OP_CLR0 : OP_CLR1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     isv_q[b] <= 1'b0;
      else if (set_b) isv_q[b] <= 1'b1;
      else if (clr_b) isv_q[b] <= 1'b0;
    end
  end

  assign inserv_o = isv_q;
  assign status_o = {busy, cmd_q};
endmodule

// File: rtl/lir_router.sv
module lir_router
  import lir_pkg::*;
#(
  parameter int BUSY_CYCLES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_slot_i,
  input  logic         src_global_i,
  input  logic         src_uart_i,
  input  logic         src_timer_i,
  input  logic         route_we_i,
  input  logic [15:0]  route_wdata_i,
  input  logic         mask_we_i,
  input  logic [7:0]   mask_wdata_i,
  input  logic         ack_valid_i,
  input  logic [2:0]   ack_level_i,
  input  logic         ack_sel_i,
  input  logic         cmd_we_i,
  input  logic [7:0]   cmd_wdata_i,
  output logic [15:0]  route_o,
  output logic [7:0]   mask_o,
  output logic [7:0]   pending_o,
  output logic [7:0]   masked_pending_o,
  output logic [1:0]   inserv_o,
  output logic [8:0]   cmd_status_o,
  output logic         ipi_valid_o,
  output logic [1:0]   ipi_kind_o,
  output logic [3:0]   ipi_target_o
);
  logic [SRC_N-1:0] src_req;
  logic [NLVL-1:0]  lvl_hit;
  logic             cmd_accept;
  logic             cmd_exec;

  always_comb begin
    src_req             = '0;
    src_req[SRC_TIMER]  = src_timer_i;
    src_req[SRC_UART]   = src_uart_i;
    src_req[SRC_GLOBAL] = src_global_i;
    src_req[SRC_SLOT]   = src_slot_i;
  end

  lir_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (route_we_i),
    .wdata_i   (route_wdata_i),
    .src_req_i (src_req),
    .route_o   (route_o),
    .lvl_hit_o (lvl_hit)
  );

  lir_pending u_pend (
    .clk              (clk),
    .rst_n            (rst_n),
    .lvl_hit_i        (lvl_hit),
    .ack_valid_i      (ack_valid_i),
    .ack_level_i      (ack_level_i),
    .mask_we_i        (mask_we_i),
    .mask_wdata_i     (mask_wdata_i),
    .pending_o        (pending_o),
    .mask_o           (mask_o),
    .masked_pending_o (masked_pending_o)
  );

  lir_cmd #(.BUSY_CYCLES(BUSY_CYCLES)) u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we_i     (cmd_we_i),
    .cmd_wdata_i  (cmd_wdata_i),
    .ack_valid_i  (ack_valid_i),
    .ack_sel_i    (ack_sel_i),
    .status_o     (cmd_status_o),
    .inserv_o     (inserv_o),
    .ipi_valid_o  (ipi_valid_o),
    .ipi_kind_o   (ipi_kind_o),
    .ipi_target_o (ipi_target_o),
    .accept_o     (cmd_accept),
    .exec_o       (cmd_exec)
  );
endmodule

// File: rtl/lir_router_chk.sv
module lir_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        src_slot_i,
  input logic        src_global_i,
  input logic        src_uart_i,
  input logic        src_timer_i,
  input logic        route_we_i,
  input logic [15:0] route_wdata_i,
  input logic        ack_valid_i,
  input logic [2:0]  ack_level_i,
  input logic        ack_sel_i,
  input logic        cmd_we_i,
  input logic [7:0]  cmd_wdata_i,
  input logic [15:0] route_o,
  input logic [7:0]  pending_o,
  input logic [1:0]  inserv_o,
  input logic [8:0]  cmd_status_o,
  input logic        ipi_valid_o
);
  logic ack_hit;
  always_comb begin
    ack_hit = 1'b0;
    if (ack_level_i != 3'd0) begin
      if (src_timer_i  && route_o[2:0]   == ack_level_i) ack_hit = 1'b1;
      if (src_uart_i   && route_o[6:4]   == ack_level_i) ack_hit = 1'b1;
      if (src_global_i && route_o[10:8]  == ack_level_i) ack_hit = 1'b1;
      if (src_slot_i   && route_o[14:12] == ack_level_i) ack_hit = 1'b1;
    end
  end

  AST_ROUTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    route_we_i |=> route_o == ($past(route_wdata_i) & 16'h7777)); // R2
  AST_TIMER_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_timer_i && route_o[2:0] != 3'd0) |=> pending_o[$past(route_o[2:0])]); // R3
  AST_LEVEL0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_o[0]); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_i && !ack_hit && ack_level_i != 3'd0) |=> !pending_o[$past(ack_level_i)]); // R6
  AST_ACK_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_i |=> inserv_o[$past(ack_sel_i)]); // R6
  AST_CMD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && !cmd_status_o[8]) |=> (cmd_status_o[8] && cmd_status_o[7:0] == $past(cmd_wdata_i))); // R7
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_status_o[8]) |=> $stable(cmd_status_o[7:0])); // R12
  AST_IPI_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid_o |-> cmd_status_o[8]); // R8
endmodule

bind lir_router lir_router_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_slot_i    (src_slot_i),
  .src_global_i  (src_global_i),
  .src_uart_i    (src_uart_i),
  .src_timer_i   (src_timer_i),
  .route_we_i    (route_we_i),
  .route_wdata_i (route_wdata_i),
  .ack_valid_i   (ack_valid_i),
  .ack_level_i   (ack_level_i),
  .ack_sel_i     (ack_sel_i),
  .cmd_we_i      (cmd_we_i),
  .cmd_wdata_i   (cmd_wdata_i),
  .route_o       (route_o),
  .pending_o     (pending_o),
  .inserv_o      (inserv_o),
  .cmd_status_o  (cmd_status_o),
  .ipi_valid_o   (ipi_valid_o)
);

// File: tb/tb_lir_router.sv
`timescale 1ns/1ps
module tb_lir_router;
  localparam int BUSY = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_slot_i = 0, src_global_i = 0, src_uart_i = 0, src_timer_i = 0;
  logic        route_we_i = 0;
  logic [15:0] route_wdata_i = '0;
  logic        mask_we_i = 0;
  logic [7:0]  mask_wdata_i = '0;
  logic        ack_valid_i = 0;
  logic [2:0]  ack_level_i = '0;
  logic        ack_sel_i = 0;
  logic        cmd_we_i = 0;
  logic [7:0]  cmd_wdata_i = '0;
  logic [15:0] route_o;
  logic [7:0]  mask_o, pending_o, masked_pending_o;
  logic [1:0]  inserv_o;
  logic [8:0]  cmd_status_o;
  logic        ipi_valid_o;
  logic [1:0]  ipi_kind_o;
  logic [3:0]  ipi_target_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_q[$];

  always #5 clk = ~clk;

  lir_router #(.BUSY_CYCLES(BUSY)) dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: compare each outgoing interrupt against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && ipi_valid_o) begin
      if (exp_q.size() == 0) begin
        chk("R12 unexpected ipi", {26'd0, ipi_kind_o, ipi_target_o}, 32'h3F);
      end else begin
        logic [5:0] e;
        e = exp_q.pop_front();
        chk("R8/R9/R10 ipi kind+target", {26'd0, ipi_kind_o, ipi_target_o}, {26'd0, e});
      end
    end
  end

  task automatic wait_idle();
    while (cmd_status_o[8]) step();
  endtask

  task automatic issue(logic [7:0] code, bit want_ipi, logic [1:0] kind, logic [3:0] tgt);
    wait_idle();
    cmd_wdata_i = code;
    cmd_we_i = 1'b1;
    step();
    cmd_we_i = 1'b0;
    chk("R7 status after accept", cmd_status_o, {1'b1, code});
    if (want_ipi) exp_q.push_back({kind, tgt});
    step();
    chk("R8 ipi strobe timing", ipi_valid_o, want_ipi);
    wait_idle();
  endtask

  task automatic pulse(bit t, bit u, bit g, bit s);
    src_timer_i = t; src_uart_i = u; src_global_i = g; src_slot_i = s;
    step();
    src_timer_i = 0; src_uart_i = 0; src_global_i = 0; src_slot_i = 0;
  endtask

  task automatic ack(logic [2:0] lvl, bit sel);
    ack_level_i = lvl; ack_sel_i = sel; ack_valid_i = 1'b1;
    step();
    ack_valid_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 route default", route_o, 16'h1032);
    chk("R1 mask", mask_o, 0);
    chk("R1 pending", pending_o, 0);
    chk("R1 inserv", inserv_o, 0);
    chk("R1 status", cmd_status_o, 0);
    chk("R1 ipi idle", ipi_valid_o, 0);

    // R2 reserved bits read zero
    route_wdata_i = 16'hFFFF; route_we_i = 1; step(); route_we_i = 0;
    chk("R2 reserved bits", route_o, 16'h7777);
    route_wdata_i = 16'h1032; route_we_i = 1; step(); route_we_i = 0;
    chk("R2 route readback", route_o, 16'h1032);

    // R3 timer at level 2
    pulse(1, 0, 0, 0);
    chk("R3 timer level 2", pending_o, 8'h04);
    // R3 broadcast request disabled by default
    pulse(0, 0, 1, 0);
    chk("R3 disabled source", pending_o, 8'h04);
    // R3 slot level 1, serial port level 3
    pulse(0, 1, 0, 1);
    chk("R3 slot and uart", pending_o, 8'h0E);

    // R4 shared level and level 0
    route_wdata_i = 16'h5050; route_we_i = 1; step(); route_we_i = 0;
    pulse(0, 1, 0, 1);
    chk("R4 shared level 5", pending_o, 8'h2E);
    route_wdata_i = 16'h0000; route_we_i = 1; step(); route_we_i = 0;
    pulse(1, 1, 1, 1);
    chk("R4 all disabled", pending_o, 8'h2E);

    // R5 mask blocks level but pending still captured
    mask_wdata_i = 8'h24; mask_we_i = 1; step(); mask_we_i = 0;
    chk("R5 masked pending", masked_pending_o, 8'h2E & ~8'h24);
    route_wdata_i = 16'h0700; route_we_i = 1; step(); route_we_i = 0;
    pulse(0, 0, 1, 0);
    chk("R5 masked level captured", pending_o, 8'hAE);
    chk("R5 masked level hidden", masked_pending_o, 8'hAE & ~8'h24);

    // R6 acknowledge clears pending and sets in-service
    ack(3'd2, 1'b0);
    chk("R6 ack clears", pending_o, 8'hAA);
    chk("R6 inserv0 set", inserv_o, 2'b01);
    ack_level_i = 3'd7; ack_sel_i = 1'b1; ack_valid_i = 1'b1; src_global_i = 1'b1;
    step();
    ack_valid_i = 1'b0; src_global_i = 1'b0;
    chk("R6 source wins over ack", pending_o, 8'hAA);
    chk("R6 inserv1 set", inserv_o, 2'b11);

    // R8 slot IPI, R12 busy window
    exp_q.push_back({2'd0, 4'd5});
    cmd_wdata_i = 8'h65; cmd_we_i = 1; step(); cmd_we_i = 0;
    chk("R7 slot accepted", cmd_status_o, 9'h165);
    begin
      int n = 1;
      step();
      chk("R8 slot ipi strobe", ipi_valid_o, 1);
      cmd_wdata_i = 8'hE8; cmd_we_i = 1;
      while (cmd_status_o[8]) begin
        step();
        cmd_we_i = 0;
        if (cmd_status_o[8]) n++;
        else break;
        n = n;
      end
      chk("R12 busy length", n + 1, BUSY + 1);
    end
    chk("R12 write while busy ignored", cmd_status_o, 9'h065);
    chk("R12 inserv untouched", inserv_o, 2'b11);

    // R9 broadcast, R10 forward at level
    issue(8'hE0, 1, 2'd1, 4'd0);
    issue(8'h27, 1, 2'd2, 4'd7);
    issue(8'h6F, 1, 2'd0, 4'd15);

    // R11 clears
    issue(8'hE8, 0, 2'd0, 4'd0);
    chk("R11 clear inserv0", inserv_o, 2'b10);
    issue(8'hE9, 0, 2'd0, 4'd0);
    chk("R11 clear inserv1", inserv_o, 2'b00);

    // R13 unrecognized code
    ack(3'd1, 1'b0);
    issue(8'h55, 0, 2'd0, 4'd0);
    chk("R13 inserv unchanged", inserv_o, 2'b01);

    step();
    chk("R8 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule